// File: doc/BRIEF.md
# Two-Digit Modulo-60 BCD Up/Down Counter

This block keeps a count from 00 to 59 as two binary-coded decimal digits, a units digit and a tens digit, each held in its own 4-bit register. On every rising clock edge with the count enable high, the count moves by one. The direction input sets whether it moves up or down. The count wraps between 59 and 00 in both directions, so the block suits minute or second counters and similar timekeeping.

A synchronous clear returns both digits to zero and overrides every other input. Each digit has its own combinational seven-segment decoder, and each decoder drives a separate active-low output bus. The two digits never share a display line. Multiplexing the digits onto one display, debouncing the inputs and dividing the clock are left to the surrounding logic.

Top module: `bcd_mod60_counter`

## Requirements
- R1: When `clear` is high at a rising clock edge, both digits become 0 at that edge, whatever the values of `count_en` and `count_up`.
- R2: When `clear` is low and `count_en` is low at a rising edge, both digits keep their values.
- R3: Counting up (`count_up` high), the units digit steps from 9 to 0 and the tens digit goes up by one at that same edge. At any other units value, only the units digit changes.
- R4: Counting up from 59 gives 00.
- R5: Counting down (`count_up` low), the units digit steps from 0 to 9 and the tens digit goes down by one at that same edge. At any other units value, only the units digit changes.
- R6: Counting down from 00 gives 59.
- R7: Each output bus carries the segments a..g at bits 6..0 and is active low, so a lit segment drives a 0. The lit patterns (1 means lit, bits 6..0) are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011.
- R8: `units_seg_n` shows only the units digit and `tens_seg_n` shows only the tens digit. Each output changes only when its own digit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous clear to 00, highest priority |
| count_en | input | 1 | Count enable; high lets the count move |
| count_up | input | 1 | Direction: 1 counts up, 0 counts down |
| units_seg_n | output | 7 | Active-low segments a..g (bit 6..0) for the units digit |
| tens_seg_n | output | 7 | Active-low segments a..g (bit 6..0) for the tens digit |

## Verification
The bench builds the block with its default parameters: 4-bit digits, a units limit of 9 and a tens limit of 5. With these values a full lap of the count takes only 60 enabled edges, so the bench walks every value in both directions and crosses both wrap points, 59 to 00 and 00 to 59. Because the bench reads the count only through the segment buses, every step checks all ten decoder patterns on the units output and six on the tens output. It also checks that holding the enable low freezes the count and that clear wins over an active enable.

// File: rtl/bcd_mod60_pkg.sv
package bcd_mod60_pkg;
  localparam int DIGIT_W  = 4;
  localparam int SEG_W    = 7;
  localparam int N_DIGITS = 2;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;

  // Highest value each digit position reaches before wrapping.
  function automatic int unsigned digit_limit(input int unsigned pos);
    return (pos == 0) ? 9 : 5;
  endfunction
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell #(
  parameter int W   = 4,
  parameter int MAX = 9
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         step,
  input  logic         up,
  output logic [W-1:0] value,
  output logic         at_edge
);
  localparam logic [W-1:0] TOP = W'(MAX);

  always_ff @(posedge clk) begin
    if (clear)
      value <= '0;
    else if (step) begin
      if (up)
        value <= (value == TOP) ? '0 : value + 1'b1;
      else
        value <= (value == '0) ? TOP : value - 1'b1;
    end
  end

  // Next step in the current direction wraps this digit.
  assign at_edge = up ? (value == TOP) : (value == '0);

  a_r1_clear_zero: assert property (@(posedge clk) clear |=> value == '0);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (clear)
    !step |=> $stable(value));
  a_r3_in_range: assert property (@(posedge clk) disable iff (clear)
    $past(!clear) |-> value <= TOP);
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_mod60_pkg::*;
(
  input  digit_t digit,
  output seg_t   seg_n
);
  seg_t lit;

  always_comb begin
    unique case (digit)
      4'd0:    lit = 7'b1111110;
      4'd1:    lit = 7'b0110000;
      4'd2:    lit = 7'b1101101;
      4'd3:    lit = 7'b1111001;
      4'd4:    lit = 7'b0110011;
      4'd5:    lit = 7'b1011011;
      4'd6:    lit = 7'b1011111;
      4'd7:    lit = 7'b1110000;
      4'd8:    lit = 7'b1111111;
      4'd9:    lit = 7'b1111011;
      default: lit = '0;
    endcase
    seg_n = ~lit;
  end

  // R7: every decimal digit lights at least two segments.
  always_comb begin
    if (digit <= 4'd9)
      a_r7_digit_lit: assert ($countones(~seg_n) >= 2);
  end
endmodule

// File: rtl/bcd_mod60_counter.sv
module bcd_mod60_counter
  import bcd_mod60_pkg::*;
(
  input  logic             clk,
  input  logic             clear,
  input  logic             count_en,
  input  logic             count_up,
  output logic [SEG_W-1:0] units_seg_n,
  output logic [SEG_W-1:0] tens_seg_n
);
  digit_t digit_q [N_DIGITS];
  seg_t   seg_q   [N_DIGITS];
  logic   edge_q  [N_DIGITS];
  logic   step_c  [N_DIGITS+1];

  assign step_c[0] = count_en;

  for (genvar i = 0; i < N_DIGITS; i++) begin : g_digit
    bcd_digit_cell #(
      .W  (DIGIT_W),
      .MAX(int'(digit_limit(i)))
    ) u_cell (
      .clk    (clk),
      .clear  (clear),
      .step   (step_c[i]),
      .up     (count_up),
      .value  (digit_q[i]),
      .at_edge(edge_q[i])
    );
    assign step_c[i+1] = step_c[i] & edge_q[i];

    bcd_seg_decoder u_dec (
      .digit(digit_q[i]),
      .seg_n(seg_q[i])
    );
  end

  assign units_seg_n = seg_q[0];
  assign tens_seg_n  = seg_q[1];

  a_r4_wrap_up: assert property (@(posedge clk) disable iff (clear)
    (count_en && count_up && digit_q[0] == 4'd9 && digit_q[1] == 4'd5)
    |=> (digit_q[0] == 4'd0 && digit_q[1] == 4'd0));
  a_r6_wrap_down: assert property (@(posedge clk) disable iff (clear)
    (count_en && !count_up && digit_q[0] == 4'd0 && digit_q[1] == 4'd0)
    |=> (digit_q[0] == 4'd9 && digit_q[1] == 4'd5));
  a_r3_carry: assert property (@(posedge clk) disable iff (clear)
    (count_en && count_up && digit_q[0] != 4'd9) |=> $stable(digit_q[1]));
  a_r5_borrow: assert property (@(posedge clk) disable iff (clear)
    (count_en && !count_up && digit_q[0] != 4'd0) |=> $stable(digit_q[1]));
  a_r8_tens_quiet: assert property (@(posedge clk) disable iff (clear)
    $stable(digit_q[1]) |-> $stable(tens_seg_n));
endmodule

// File: tb/bcd_mod60_counter_bench.sv
module bcd_mod60_counter_bench;
  logic clk = 0;
  logic clear = 1, count_en = 0, count_up = 1;
  logic [6:0] units_seg_n, tens_seg_n;
  int checks = 0, fails = 0;
  int m_u = 0, m_t = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bcd_mod60_counter u_bcd_mod60_counter (
    .clk(clk), .clear(clear), .count_en(count_en), .count_up(count_up),
    .units_seg_n(units_seg_n), .tens_seg_n(tens_seg_n));

  function automatic logic [6:0] exp_seg(input int d);
    logic [6:0] lit;
    case (d)
      0: lit = 7'b1111110;  1: lit = 7'b0110000;  2: lit = 7'b1101101;
      3: lit = 7'b1111001;  4: lit = 7'b0110011;  5: lit = 7'b1011011;
      6: lit = 7'b1011111;  7: lit = 7'b1110000;  8: lit = 7'b1111111;
      default: lit = 7'b1111011;
    endcase
    return ~lit;
  endfunction

  task automatic check(input string req);
    checks++;
    if (units_seg_n !== exp_seg(m_u) || tens_seg_n !== exp_seg(m_t)) begin
      fails++;
      $display("FAIL %s: got tens=%b units=%b expected tens=%b units=%b (count %0d%0d)",
               req, tens_seg_n, units_seg_n, exp_seg(m_t), exp_seg(m_u), m_t, m_u);
    end
  endtask

  // One clock with given inputs; model update; sample at the falling edge.
  task automatic tick(input logic clr, input logic en, input logic up, input string req);
    clear = clr; count_en = en; count_up = up;
    @(posedge clk);
    @(negedge clk);
    if (clr) begin m_u = 0; m_t = 0; end
    else if (en) begin
      if (up) begin
        if (m_u == 9) begin m_u = 0; m_t = (m_t == 5) ? 0 : m_t + 1; end
        else m_u++;
      end else begin
        if (m_u == 0) begin m_u = 9; m_t = (m_t == 0) ? 5 : m_t - 1; end
        else m_u--;
      end
    end
    check(req);
  endtask

  task automatic t_reset();
    tick(1, 0, 1, "R1 reset");
    tick(1, 1, 0, "R1 clear with enable");
  endtask

  task automatic t_full_up();
    for (int k = 0; k < 62; k++)
      tick(0, 1, 1, (m_u == 9) ? ((m_t == 5) ? "R4 wrap 59->00" : "R3 carry") : "R7 R8 up step");
  endtask

  task automatic t_full_down();
    for (int k = 0; k < 62; k++)
      tick(0, 1, 0, (m_u == 0) ? ((m_t == 0) ? "R6 wrap 00->59" : "R5 borrow") : "R7 R8 down step");
  endtask

  task automatic t_hold();
    for (int k = 0; k < 4; k++) tick(0, 1, 1, "R3 advance");
    for (int k = 0; k < 5; k++) tick(0, 0, k[0], "R2 hold");
  endtask

  task automatic t_clear_wins();
    for (int k = 0; k < 13; k++) tick(0, 1, 1, "R3 advance");
    tick(1, 1, 1, "R1 clear over enable up");
    tick(0, 1, 0, "R6 wrap after clear");
    tick(1, 1, 0, "R1 clear over enable down");
  endtask

  task automatic t_direction_flip();
    tick(0, 1, 1, "R3 up");
    tick(0, 1, 0, "R5 down");
    tick(0, 1, 0, "R6 wrap down");
    tick(0, 1, 1, "R4 wrap up");
  endtask

  initial begin
    t_reset();
    t_full_up();
    t_full_down();
    t_hold();
    t_clear_wins();
    t_direction_flip();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule